// File: doc/BRIEF.md
# Synchronous Peripheral Bus Cycle Generator

This block takes the place of the slow, E-locked peripheral cycle that a 68000-style CPU runs for 6800-style peripheral chips. An accelerator that removes the original CPU still has to serve those chips. The block supplies the E clock and drives the active-low valid-memory-address strobe (VMA). It then closes each peripheral access with an active-low, DTACK-style acknowledge, so the faster master sees an ordinary asynchronous handshake.

E can come from two sources. With `e_src_ext` low, E is divided down from the system clock with a 10-clock period, for boards that have no host CPU. With `e_src_ext` high, an outside E is brought in through a two-flop synchronizer and passed on. The access request (`vpa_n`) comes from external address decoding. The block only reads it.

The controller is a five-state machine:
- IDLE: no access in progress.
- WAIT_LOW: the request arrived while E was high, so the machine waits for the low phase.
- VMA_LOW: VMA is asserted and E is still low.
- VMA_HIGH: VMA is asserted during E high.
- ACK: the acknowledge is asserted.

Transitions:
- IDLE→VMA_LOW when the strobe and request are both seen while E is low.
- IDLE→WAIT_LOW when they are seen while E is high.
- WAIT_LOW→VMA_LOW when E is low.
- VMA_LOW→VMA_HIGH when E is high.
- VMA_HIGH→ACK on the acknowledge strobe.
- Any state→IDLE when the address strobe is negated.
- WAIT_LOW→IDLE also when the request is withdrawn.

Top module: `periph_cycle_gen`

## Requirements
- R1: With `e_src_ext`=0, `e_out` free-runs with a period of 10 clocks, low for 6 and high for 4, whether or not an access is in progress.
- R2: With `e_src_ext`=1, `e_out` equals `e_ext` delayed by two clock edges through the synchronizer.
- R3: When `as_n` and `vpa_n` are both low in a cycle where `e_out` is low, `vma_n` goes low in the next cycle.
- R4: If the request is first seen while `e_out` is high, `vma_n` stays high until the cycle after the first cycle with `e_out` low.
- R5: Once low, `vma_n` stays low while `as_n` stays low, and goes high in the cycle after `as_n` is seen high.
- R6: In local mode, `dtack_n` goes low in the last high cycle of `e_out` (the cycle just before its falling edge) in which VMA has covered the high phase. In external mode it goes low in the cycle after the synchronized E is detected falling. In both modes it stays low until the cycle after `as_n` is seen high.
- R7: While `rst_n` is low, `e_out` is low and `vma_n` and `dtack_n` are high. After release, the local divider starts at the beginning of its low phase.
- R8: A request withdrawn (`vpa_n` high) or an `as_n` negated while waiting for E low cancels the access, and `vma_n` never goes low for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (~7 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Active-low address strobe |
| vpa_n | input | 1 | Active-low peripheral request from address decode |
| e_ext | input | 1 | External E clock (asynchronous) |
| e_src_ext | input | 1 | 1: use external E, 0: generate E locally |
| e_out | output | 1 | E clock in use |
| vma_n | output | 1 | Active-low valid memory address |
| dtack_n | output | 1 | Active-low data acknowledge |

## Verification
The bench targets requests that land on every phase of E:
- A request in the last low cycle must still start at once.
- A request in any high cycle must be held back. A design that starts VMA mid-cycle would drop `vma_n` while E is high.

Other cases:
- Short strobes end before the acknowledge. An FSM that fails to return to IDLE would leave VMA or the acknowledge stuck low.
- Requests withdrawn during the wait catch a design that latches the request.
- Running from an external E with a different period catches a wrong synchronizer depth or a wrong edge, which shows as a shifted E or a misplaced acknowledge.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_LOW,
        ST_VMA_LOW,
        ST_VMA_HIGH,
        ST_ACK
    } cyc_state_t;
endpackage

// File: rtl/pcg_e_divider.sv
// Local E generator: free-running counter, E high in the last HIGH_CYC counts.
module pcg_e_divider #(
    parameter int PERIOD  = 10,
    parameter int LOW_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic e,
    output logic fall_soon
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(PERIOD - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign e         = (cnt_q >= CW'(LOW_CYC));
    // one cycle ahead of the last high count, so a registered ack lands on it
    assign fall_soon = (cnt_q == CW'(PERIOD - 2));
endmodule

// File: rtl/pcg_e_sync.sv
// External E synchronizer and falling-edge detector.
module pcg_e_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e_in,
    output logic e_s,
    output logic fell
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], e_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign e_s  = sync_q[STAGES-1];
    assign fell = prev_q && !sync_q[STAGES-1];
endmodule

// File: rtl/pcg_cycle_fsm.sv
// Access controller: VMA start aligned to E low, acknowledge on ack_strobe.
module pcg_cycle_fsm
    import pcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic vpa_n,
    input  logic e,
    input  logic ack_strobe,
    output logic vma_n,
    output logic dtack_n
);
    cyc_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!as_n && !vpa_n) st_d = e ? ST_WAIT_LOW : ST_VMA_LOW;
            end
            ST_WAIT_LOW: begin
                if (as_n || vpa_n) st_d = ST_IDLE;
                else if (!e)       st_d = ST_VMA_LOW;
            end
            ST_VMA_LOW: begin
                if (as_n)   st_d = ST_IDLE;
                else if (e) st_d = ST_VMA_HIGH;
            end
            ST_VMA_HIGH: begin
                if (as_n)            st_d = ST_IDLE;
                else if (ack_strobe) st_d = ST_ACK;
            end
            ST_ACK: begin
                if (as_n) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        vma_n   = 1'b1;
        dtack_n = 1'b1;
        unique case (st_q)
            ST_VMA_LOW, ST_VMA_HIGH: vma_n = 1'b0;
            ST_ACK: begin
                vma_n   = 1'b0;
                dtack_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/periph_cycle_gen.sv
module periph_cycle_gen #(
    parameter int E_PERIOD   = 10,
    parameter int E_LOW      = 6,
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic vpa_n,
    input  logic e_ext,
    input  logic e_src_ext,
    output logic e_out,
    output logic vma_n,
    output logic dtack_n
);
    logic e_loc, loc_fall_soon;
    logic e_syn, syn_fell;
    logic ack_strobe;

    pcg_e_divider #(.PERIOD(E_PERIOD), .LOW_CYC(E_LOW)) u_div (
        .clk(clk), .rst_n(rst_n), .e(e_loc), .fall_soon(loc_fall_soon)
    );

    pcg_e_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .e_in(e_ext), .e_s(e_syn), .fell(syn_fell)
    );

    assign e_out      = e_src_ext ? e_syn    : e_loc;
    assign ack_strobe = e_src_ext ? syn_fell : loc_fall_soon;

    pcg_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .vpa_n(vpa_n),
        .e(e_out), .ack_strobe(ack_strobe), .vma_n(vma_n), .dtack_n(dtack_n)
    );
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
    parameter int E_PERIOD = 10,
    parameter int E_LOW    = 6
) (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic vpa_n,
    input logic e_src_ext,
    input logic e_out,
    input logic vma_n,
    input logic dtack_n
);
    logic       e_d, run_ok;
    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_d    <= 1'b0;
            run    <= 8'd1;
            run_ok <= 1'b0;
        end else begin
            e_d <= e_out;
            if (e_out != e_d) begin
                run    <= 8'd1;
                run_ok <= !e_src_ext;
            end else begin
                run <= run + 8'd1;
            end
        end
    end

    // R1: local E phases last exactly E_LOW low / E_PERIOD-E_LOW high
    a_r1_e_phase_len: assert property (@(posedge clk) disable iff (!rst_n || e_src_ext)
        (run_ok && e_out != e_d) |-> (run == (e_d ? 8'(E_PERIOD - E_LOW) : 8'(E_LOW))));

    // R3: VMA only starts after a cycle with request and E low
    a_r3_vma_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vma_n) |-> ($past(!e_out) && $past(!as_n) && $past(!vpa_n)));

    // R5: negated strobe releases VMA the next cycle
    a_r5_vma_release: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> vma_n);

    // R6: acknowledge only inside a VMA access
    a_r6_ack_in_vma: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !vma_n);
endmodule

bind periph_cycle_gen pcg_checker #(.E_PERIOD(E_PERIOD), .E_LOW(E_LOW)) u_chk (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .vpa_n(vpa_n), .e_src_ext(e_src_ext),
    .e_out(e_out), .vma_n(vma_n), .dtack_n(dtack_n)
);

// File: tb/tb_periph_cycle_gen.sv
module tb_periph_cycle_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_n = 1'b1, vpa_n = 1'b1, e_ext = 1'b0, e_src_ext = 1'b0;
    logic e_out, vma_n, dtack_n;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    periph_cycle_gen dut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .vpa_n(vpa_n), .e_ext(e_ext),
        .e_src_ext(e_src_ext), .e_out(e_out), .vma_n(vma_n), .dtack_n(dtack_n)
    );

    // reference model built from the requirements
    int m_cnt = 0;          // local E position, 0..9 (R1, R7)
    bit m_s1 = 0, m_s2 = 0, m_prev = 0;   // external E delay line (R2)
    int m_st = 0;           // 0 idle,1 wait,2 vma low,3 vma high,4 ack

    function automatic bit exp_e();
        return e_src_ext ? m_s2 : (m_cnt >= 6);
    endfunction
    function automatic bit exp_vma_n();
        return !(m_st >= 2);
    endfunction
    function automatic bit exp_dtack_n();
        return m_st != 4;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_st = 0;
        end else begin
            bit ecur, strobe;
            ecur   = exp_e();
            strobe = e_src_ext ? (!m_s2 && m_prev) : (m_cnt == 8);
            case (m_st)
                0: if (!as_n && !vpa_n) m_st = ecur ? 1 : 2;
                1: if (as_n || vpa_n) m_st = 0; else if (!ecur) m_st = 2;
                2: if (as_n) m_st = 0; else if (ecur) m_st = 3;
                3: if (as_n) m_st = 0; else if (strobe) m_st = 4;
                default: if (as_n) m_st = 0;
            endcase
            m_cnt  = (m_cnt == 9) ? 0 : m_cnt + 1;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = e_ext;
        end
    end

    task automatic chk(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // compare every cycle on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk(e_src_ext ? "R2 e_out" : "R1 e_out", e_out, exp_e());
            chk("R3 R4 R5 R8 vma_n", vma_n, exp_vma_n());
            chk("R6 dtack_n", dtack_n, exp_dtack_n());
        end
    end

    // external E: high 5, low 8, driven off the clock edge
    int ecnt = 0;
    always @(negedge clk) begin
        ecnt = (ecnt == 12) ? 0 : ecnt + 1;
        e_ext <= (ecnt < 5);
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic access(input int pre, input int gap, input int hold, input bit drop);
        wait_n(pre);
        as_n = 1'b0;
        wait_n(gap);
        vpa_n = 1'b0;
        if (drop) begin
            wait_n(1);
            vpa_n = 1'b1;   // R8 withdraw
        end
        wait_n(hold);
        as_n = 1'b1; vpa_n = 1'b1;
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0; e_src_ext = mode;
        wait_n(3);
        // R7: reset values
        chk("R7 e_out", e_out, 1'b0);
        chk("R7 vma_n", vma_n, 1'b1);
        chk("R7 dtack_n", dtack_n, 1'b1);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset(1'b0);
        // directed R3/R4: request at every E phase
        for (int ph = 0; ph < 10; ph++) begin
            access(ph, 0, 14, 1'b0);
            wait_n(10 - ((ph + 14) % 10));
        end
        // R5/R8 directed short strobe and withdrawal
        access(2, 0, 1, 1'b0);
        access(7, 0, 2, 1'b1);
        for (int i = 0; i < 150; i++)
            access($urandom_range(0, 12), $urandom_range(0, 3),
                   $urandom_range(1, 30), ($urandom_range(0, 7) == 0));
        // external E mode
        do_reset(1'b1);
        for (int i = 0; i < 150; i++)
            access($urandom_range(0, 12), $urandom_range(0, 3),
                   $urandom_range(1, 35), ($urandom_range(0, 7) == 0));
        wait_n(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule